// File: doc/BRIEF.md
# Read/Write Request Queue Arbiter with Write Drain

This block sits between the requesters of a memory controller and its DRAM command stage. Incoming requests are sorted by direction into a read queue and a write queue. Each cycle the block offers one of them to the command stage. Reads normally go first. Once the write queue fills past a high mark, the block switches into a write drain. The drain runs until the write queue falls to a low mark, and then reads take priority again. Every change of direction costs a fixed bus turnaround gap, during which nothing is offered.

Inside one direction the choice follows first-ready, first-come ordering. A request flagged as hitting the currently open row beats any request that misses. Among requests with the same flag, the oldest wins. The row-hit flag comes with the request from the bank tracker upstream and is stored with it. Requests to the same address are never reordered, whether they are in the same queue or in opposite queues. Each entry remembers which older entries share its address and stays blocked until those have left.

Top module: `rwq_arbiter`

## Requirements
- R1: Each queue holds DEPTH (32) entries. `inReady` follows only the target queue chosen by `inWrite` (0 = read queue, 1 = write queue) and is low while that queue is full. A request offered while `inReady` is low is not taken, so no extra request ever appears at the output.
- R2: Every accepted request is offered exactly once on the output, with the address, bank, row-hit flag and direction (`outWrite`: 0 = read, 1 = write) it was accepted with.
- R3: Within one direction, an issuable entry with row-hit flag 1 is offered before any entry with flag 0. Among entries with equal flags, the one accepted first is offered first.
- R4: A request is never offered while an older request to the same address is still pending in either queue.
- R5: While no drain is in progress and the write queue holds fewer than the high mark (ceil(70% of DEPTH) = 23), an issuable read is offered ahead of any write.
- R6: When the write queue holds 23 or more entries, a drain begins. The block then offers only writes until the write queue holds at most the low mark (8) entries. After that, pending reads are served first again.
- R7: When no read is issuable and a write is, the write is offered even though the write queue is below the high mark.
- R8: Between two handshakes of opposite direction there are at least TURN (6) cycles with no handshake. Take a request accepted at the end of cycle c into an empty block. If its direction matches the last direction served, it is offered in cycle c+1. If it is the other direction, it is offered in cycle c+TURN+2.
- R9: During reset `outValid` is 0 and `inReady` is 1, and after reset the block starts in the read direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Incoming request valid |
| inReady | output | 1 | Target queue of the incoming request has space |
| inWrite | input | 1 | Incoming request direction, 1 = write |
| inAddr | input | ADDR_W | Incoming request address |
| inBank | input | BANK_W | Incoming request bank |
| inRowHit | input | 1 | Incoming request hits the open row of its bank |
| outValid | output | 1 | A selected request is offered |
| outReady | input | 1 | Command stage takes the offered request |
| outWrite | output | 1 | Direction of the offered request |
| outAddr | output | ADDR_W | Address of the offered request |
| outBank | output | BANK_W | Bank of the offered request |
| outRowHit | output | 1 | Row-hit flag of the offered request |

## Verification
A stale dependency bit or a lost valid bit shows up at the ports as a request that never appears. It can also appear as a same-address pair coming out in the wrong order, and this is visible on the very next handshake of that pair. A wrong occupancy count shows up as `inReady` falling early or late around the 32nd entry. It can also show up as the drain starting or ending on the wrong write, which the drain sequence exposes within one pass of 25 handshakes. A broken turnaround counter changes how many cycles a lone opposite-direction request waits before it is offered. That wait is measured exactly, from acceptance to the first cycle it is offered.

// File: rtl/rwq_pkg.sv
package rwq_pkg;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } rwqDir_t;

  // control -> datapath strobes
  typedef struct packed {
    logic popRd;
    logic popWr;
  } rwqStrobe_t;

endpackage

// File: rtl/rwq_store.sv
module rwq_store
  import rwq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 32,
  parameter int BANK_W = 3,
  parameter int AGE_W  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inWrite,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [BANK_W-1:0] inBank,
  input  logic              inRowHit,
  output logic              inReady,
  input  rwqStrobe_t        strobe,
  input  rwqDir_t           selDir,
  output logic [1:0]        eligAny,
  output logic [CNT_W-1:0]  wrCount,
  output logic [ADDR_W-1:0] outAddr,
  output logic [BANK_W-1:0] outBank,
  output logic              outRowHit
);

  // index 0 = read queue, index 1 = write queue
  logic [DEPTH-1:0]  validQ [2];
  logic [DEPTH-1:0]  hitQ   [2];
  logic [ADDR_W-1:0] addrQ  [2][DEPTH];
  logic [BANK_W-1:0] bankQ  [2][DEPTH];
  logic [AGE_W-1:0]  ageQ   [2][DEPTH];
  // depQ[q][i][p]: older same-address entries of queue p that entry i waits on
  logic [DEPTH-1:0]  depQ   [2][DEPTH][2];
  logic [CNT_W-1:0]  cntQ   [2];

  logic [DEPTH-1:0]  eligQ     [2];
  logic [DEPTH-1:0]  popMask   [2];
  logic [DEPTH-1:0]  matchMask [2];
  logic [IDX_W-1:0]  pickIdx   [2];

  logic              tgt;
  logic              enq;
  logic [1:0]        enqVec;
  logic [1:0]        popVec;
  logic [IDX_W-1:0]  freeIdx;
  logic              selQ;

  assign tgt     = inWrite;
  assign inReady = (cntQ[tgt] != CNT_W'(DEPTH));
  assign enq     = inValid && inReady;
  assign enqVec  = enq ? (tgt ? 2'b10 : 2'b01) : 2'b00;
  assign popVec  = {strobe.popWr, strobe.popRd};
  assign wrCount = cntQ[1];

  // an entry may issue once nothing older with its address is pending
  always_comb begin
    for (int q = 0; q < 2; q++) begin
      for (int i = 0; i < DEPTH; i++) begin
        eligQ[q][i] = validQ[q][i] && (depQ[q][i][0] == '0) && (depQ[q][i][1] == '0);
      end
    end
  end

  always_comb begin
    for (int q = 0; q < 2; q++) begin
      popMask[q] = '0;
      if (popVec[q]) popMask[q][pickIdx[q]] = 1'b1;
    end
  end

  // same-address entries that stay behind after this cycle's pop
  always_comb begin
    for (int q = 0; q < 2; q++) begin
      for (int i = 0; i < DEPTH; i++) begin
        matchMask[q][i] = validQ[q][i] && !popMask[q][i] && (addrQ[q][i] == inAddr);
      end
    end
  end

  always_comb begin
    freeIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!validQ[tgt][i]) freeIdx = IDX_W'(i);
    end
  end

  // per-queue picker: row hit first, then oldest, then lowest slot
  for (genvar q = 0; q < 2; q++) begin : g_pick
    logic             found;
    logic [IDX_W-1:0] best;
    logic             bestHit;
    logic [AGE_W-1:0] bestAge;

    always_comb begin
      found   = 1'b0;
      best    = '0;
      bestHit = 1'b0;
      bestAge = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (eligQ[q][i]) begin
          if (!found || (hitQ[q][i] && !bestHit) ||
              ((hitQ[q][i] == bestHit) && (ageQ[q][i] > bestAge))) begin
            found   = 1'b1;
            best    = IDX_W'(i);
            bestHit = hitQ[q][i];
            bestAge = ageQ[q][i];
          end
        end
      end
    end

    assign pickIdx[q] = best;
    assign eligAny[q] = found;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < 2; q++) begin
        validQ[q] <= '0;
        cntQ[q]   <= '0;
      end
    end else begin
      for (int q = 0; q < 2; q++) begin
        cntQ[q] <= cntQ[q] + CNT_W'(enqVec[q]) - CNT_W'(popVec[q]);
        for (int i = 0; i < DEPTH; i++) begin
          if (popMask[q][i]) validQ[q][i] <= 1'b0;
          for (int p = 0; p < 2; p++) begin
            depQ[q][i][p] <= depQ[q][i][p] & ~popMask[p];
          end
          if (enqVec[q] && validQ[q][i] && (ageQ[q][i] != '1)) begin
            ageQ[q][i] <= ageQ[q][i] + AGE_W'(1);
          end
          if (enqVec[q] && (IDX_W'(i) == freeIdx)) begin
            validQ[q][i] <= 1'b1;
            hitQ[q][i]   <= inRowHit;
            addrQ[q][i]  <= inAddr;
            bankQ[q][i]  <= inBank;
            ageQ[q][i]   <= '0;
            for (int p = 0; p < 2; p++) begin
              depQ[q][i][p] <= matchMask[p];
            end
          end
        end
      end
    end
  end

  assign selQ      = (selDir == DIR_WR);
  assign outAddr   = addrQ[selQ][pickIdx[selQ]];
  assign outBank   = bankQ[selQ][pickIdx[selQ]];
  assign outRowHit = hitQ[selQ][pickIdx[selQ]];

  AST_COUNT_MATCH_RD : assert property (@(posedge clk) disable iff (!rstN)
    $countones(validQ[0]) == int'(cntQ[0])); // R1
  AST_COUNT_MATCH_WR : assert property (@(posedge clk) disable iff (!rstN)
    $countones(validQ[1]) == int'(cntQ[1])); // R1
  AST_POP_HAS_ENTRY_RD : assert property (@(posedge clk) disable iff (!rstN)
    strobe.popRd |-> eligAny[0]); // R2
  AST_POP_HAS_ENTRY_WR : assert property (@(posedge clk) disable iff (!rstN)
    strobe.popWr |-> eligAny[1]); // R2

endmodule

// File: rtl/rwq_ctrl.sv
module rwq_ctrl
  import rwq_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int TURN    = 6,
  parameter int HI_PCT  = 70,
  parameter int LO_MARK = 8,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int HI_MARK = (DEPTH * HI_PCT + 99) / 100,
  localparam int TURN_W  = $clog2(TURN + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       eligAny,
  input  logic [CNT_W-1:0] wrCount,
  input  logic             outReady,
  output logic             outValid,
  output rwqDir_t          curDir,
  output rwqStrobe_t       strobe
);

  logic              drainQ;
  logic              drainEff;
  rwqDir_t           wantDir;
  logic              switching;
  logic              curElig;
  logic              fire;
  logic [TURN_W-1:0] turnCnt;

  // drain: starts at the high mark, stops once at or below the low mark
  assign drainEff = (drainQ || (wrCount >= CNT_W'(HI_MARK))) &&
                    (wrCount > CNT_W'(LO_MARK));

  always_comb begin
    if (drainEff && eligAny[1])  wantDir = DIR_WR;
    else if (eligAny[0])         wantDir = DIR_RD;
    else if (eligAny[1])         wantDir = DIR_WR;
    else                         wantDir = curDir;
  end

  assign switching = (turnCnt == '0) && (wantDir != curDir);
  assign curElig   = (curDir == DIR_WR) ? eligAny[1] : eligAny[0];
  assign outValid  = (turnCnt == '0) && (wantDir == curDir) && curElig;
  assign fire      = outValid && outReady;

  assign strobe.popRd = fire && (curDir == DIR_RD);
  assign strobe.popWr = fire && (curDir == DIR_WR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curDir  <= DIR_RD;
      turnCnt <= '0;
      drainQ  <= 1'b0;
    end else begin
      drainQ <= drainEff;
      if (switching) begin
        curDir  <= wantDir;
        turnCnt <= TURN_W'(TURN);
      end else if (turnCnt != '0) begin
        turnCnt <= turnCnt - TURN_W'(1);
      end
    end
  end

  // checker state: idle cycles since the last handshake
  logic [TURN_W-1:0] gapCnt;
  rwqDir_t           lastDir;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt  <= '0;
      lastDir <= DIR_RD;
    end else if (fire) begin
      gapCnt  <= '0;
      lastDir <= curDir;
    end else if (gapCnt != TURN_W'(TURN)) begin
      gapCnt <= gapCnt + TURN_W'(1);
    end
  end

  AST_TURN_GAP : assert property (@(posedge clk) disable iff (!rstN)
    (fire && (curDir != lastDir)) |-> (gapCnt >= TURN_W'(TURN))); // R8
  AST_DRAIN_EXCL : assert property (@(posedge clk) disable iff (!rstN)
    (drainQ && (wrCount > CNT_W'(LO_MARK)) && eligAny[1]) |-> !strobe.popRd); // R6
  AST_READ_FIRST : assert property (@(posedge clk) disable iff (!rstN)
    (!drainQ && (wrCount < CNT_W'(HI_MARK)) && eligAny[0]) |-> !strobe.popWr); // R5

endmodule

// File: rtl/rwq_arbiter.sv
module rwq_arbiter
  import rwq_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int ADDR_W  = 32,
  parameter int BANK_W  = 3,
  parameter int AGE_W   = 8,
  parameter int TURN    = 6,
  parameter int HI_PCT  = 70,
  parameter int LO_MARK = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inWrite,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [BANK_W-1:0] inBank,
  input  logic              inRowHit,
  output logic              outValid,
  input  logic              outReady,
  output logic              outWrite,
  output logic [ADDR_W-1:0] outAddr,
  output logic [BANK_W-1:0] outBank,
  output logic              outRowHit
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  rwqStrobe_t       strobe;
  rwqDir_t          curDir;
  logic [1:0]       eligAny;
  logic [CNT_W-1:0] wrCount;

  rwq_store #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .AGE_W(AGE_W)
  ) u_store (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inWrite(inWrite), .inAddr(inAddr),
    .inBank(inBank), .inRowHit(inRowHit), .inReady(inReady),
    .strobe(strobe), .selDir(curDir),
    .eligAny(eligAny), .wrCount(wrCount),
    .outAddr(outAddr), .outBank(outBank), .outRowHit(outRowHit)
  );

  rwq_ctrl #(
    .DEPTH(DEPTH), .TURN(TURN), .HI_PCT(HI_PCT), .LO_MARK(LO_MARK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .eligAny(eligAny), .wrCount(wrCount), .outReady(outReady),
    .outValid(outValid), .curDir(curDir), .strobe(strobe)
  );

  assign outWrite = (curDir == DIR_WR);

endmodule

// File: tb/rwq_arbiter_tb.sv
module rwq_arbiter_tb;

  localparam int TURN = 6;
  localparam int NV   = 8;
  // {write, rowHit, bank[2:0], addr[31:0]}
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd0, 32'h0000_1000},
    {1'b0, 1'b1, 3'd5, 32'h0000_1004},
    {1'b1, 1'b0, 3'd2, 32'h0000_2000},
    {1'b1, 1'b1, 3'd7, 32'h0000_2040},
    {1'b0, 1'b0, 3'd3, 32'h0000_1008},
    {1'b1, 1'b0, 3'd1, 32'hFFFF_FFF0},
    {1'b0, 1'b1, 3'd6, 32'h0000_0000},
    {1'b0, 1'b0, 3'd4, 32'hABCD_0000}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid, inReady, inWrite, inRowHit;
  logic [31:0] inAddr;
  logic [2:0]  inBank;
  logic        outValid, outReady, outWrite, outRowHit;
  logic [31:0] outAddr;
  logic [2:0]  outBank;

  int checks = 0;
  int fails  = 0;
  int cycleNo = 0;
  int lastHs  = -1000;
  logic lastHsW = 1'b0;
  logic haveHs  = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cycleNo <= cycleNo + 1;

  rwq_arbiter u_dut (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady), .inWrite(inWrite),
    .inAddr(inAddr), .inBank(inBank), .inRowHit(inRowHit),
    .outValid(outValid), .outReady(outReady), .outWrite(outWrite),
    .outAddr(outAddr), .outBank(outBank), .outRowHit(outRowHit)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // starts and ends just after a falling edge
  task automatic push(input logic w, input logic hit, input logic [2:0] bank,
                      input logic [31:0] addr);
    inValid = 1'b1; inWrite = w; inRowHit = hit; inBank = bank; inAddr = addr;
    #1;
    chk(inReady, "R1", "inReady before push", {63'd0, inReady}, 64'd1);
    @(posedge clk); #1;
    inValid = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic popOne(output logic w, output logic hit, output logic [2:0] bank,
                        output logic [31:0] addr, output int waited);
    waited = 0;
    outReady = 1'b1;
    #0;
    while (!outValid && waited < 300) begin
      @(negedge clk); #1;
      waited++;
    end
    w = outWrite; hit = outRowHit; bank = outBank; addr = outAddr;
    if (outValid) begin
      // R8: idle gap on direction change, measured at each handshake
      if (haveHs && (outWrite != lastHsW)) begin
        chk((cycleNo - lastHs - 1) >= TURN, "R8", "idle gap on turnaround",
            64'(cycleNo - lastHs - 1), 64'(TURN));
      end
      haveHs  = 1'b1;
      lastHsW = outWrite;
      lastHs  = cycleNo;
    end else begin
      chk(1'b0, "R2", "request never offered", 64'd0, 64'd1);
    end
    @(posedge clk); #1;
    outReady = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic expectPop(input string req, input logic w, input logic [31:0] addr);
    logic gw, gh; logic [2:0] gb; logic [31:0] ga; int wt;
    popOne(gw, gh, gb, ga, wt);
    chk((gw == w) && (ga == addr), req, "issue order {write,addr}",
        {31'd0, gw, ga}, {31'd0, w, addr});
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic lastW;
    logic gw, gh; logic [2:0] gb; logic [31:0] ga; int wt;

    rstN = 1'b0; inValid = 1'b0; inWrite = 1'b0; inRowHit = 1'b0;
    inAddr = '0; inBank = '0; outReady = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R9: reset state
    chk(outValid == 1'b0, "R9", "outValid in reset", {63'd0, outValid}, 64'd0);
    chk(inReady == 1'b1, "R9", "inReady in reset", {63'd0, inReady}, 64'd1);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(outValid == 1'b0, "R9", "outValid idle after reset", {63'd0, outValid}, 64'd0);

    // table: lone requests, fields and exact turnaround latency (R2, R7, R8)
    lastW = 1'b0;
    for (int v = 0; v < NV; v++) begin
      logic [36:0] e;
      int expWait;
      e = VEC[v];
      expWait = (e[36] != lastW) ? TURN + 1 : 0;
      push(e[36], e[35], e[34:32], e[31:0]);
      popOne(gw, gh, gb, ga, wt);
      chk({gw, gh, gb, ga} == e, "R2", "fields of lone request",
          {27'd0, gw, gh, gb, ga}, {27'd0, e});
      chk(wt == expWait, e[36] ? "R7_R8" : "R8", "cycles until offered",
          64'(wt), 64'(expWait));
      lastW = e[36];
    end

    // R3: row hit first, then oldest
    push(1'b0, 1'b0, 3'd1, 32'h10);
    push(1'b0, 1'b1, 3'd2, 32'h20);
    push(1'b0, 1'b0, 3'd3, 32'h30);
    push(1'b0, 1'b1, 3'd4, 32'h40);
    expectPop("R3", 1'b0, 32'h20);
    expectPop("R3", 1'b0, 32'h40);
    expectPop("R3", 1'b0, 32'h10);
    expectPop("R3", 1'b0, 32'h30);

    // R4: read waits behind an older write to the same address
    push(1'b1, 1'b0, 3'd0, 32'h50);
    push(1'b0, 1'b1, 3'd0, 32'h50);
    push(1'b0, 1'b0, 3'd1, 32'h60);
    expectPop("R4", 1'b0, 32'h60);
    expectPop("R4", 1'b1, 32'h50);
    expectPop("R4", 1'b0, 32'h50);
    // R4: write waits behind an older read to the same address
    push(1'b0, 1'b0, 3'd2, 32'h70);
    push(1'b1, 1'b1, 3'd2, 32'h70);
    expectPop("R4", 1'b0, 32'h70);
    expectPop("R4", 1'b1, 32'h70);
    // R4: same-queue same address keeps order despite the row-hit flag
    push(1'b1, 1'b0, 3'd3, 32'h90);
    push(1'b1, 1'b1, 3'd3, 32'h90);
    push(1'b1, 1'b0, 3'd4, 32'hA0);
    expectPop("R4", 1'b1, 32'h90);
    expectPop("R4", 1'b1, 32'h90);
    expectPop("R4", 1'b1, 32'hA0);

    // R1: fill the read queue
    for (int i = 0; i < 32; i++) push(1'b0, 1'b0, 3'(i), 32'h300 + 32'(i));
    inWrite = 1'b0; #1;
    chk(inReady == 1'b0, "R1", "inReady for full read queue", {63'd0, inReady}, 64'd0);
    inWrite = 1'b1; #1;
    chk(inReady == 1'b1, "R1", "inReady for write while reads full", {63'd0, inReady}, 64'd1);
    inWrite = 1'b0; inAddr = 32'hDEAD; inValid = 1'b1;
    @(posedge clk); #1;
    inValid = 1'b0;
    @(negedge clk); #1;
    for (int i = 0; i < 32; i++) expectPop("R1_R3", 1'b0, 32'h300 + 32'(i));
    outReady = 1'b1; #1;
    chk(outValid == 1'b0, "R1", "no request after full queue emptied", {63'd0, outValid}, 64'd0);
    outReady = 1'b0;

    // R5 / R6: drain
    push(1'b0, 1'b0, 3'd0, 32'h200);
    push(1'b0, 1'b0, 3'd0, 32'h201);
    for (int i = 0; i < 22; i++) push(1'b1, 1'b0, 3'(i), 32'h100 + 32'(i));
    expectPop("R5", 1'b0, 32'h200);
    push(1'b1, 1'b0, 3'd6, 32'h116);
    push(1'b0, 1'b0, 3'd6, 32'h202);
    for (int i = 0; i < 15; i++) expectPop("R6", 1'b1, 32'h100 + 32'(i));
    expectPop("R6", 1'b0, 32'h201);
    expectPop("R6", 1'b0, 32'h202);
    for (int i = 15; i < 23; i++) expectPop("R7", 1'b1, 32'h100 + 32'(i));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule